// File: doc/BRIEF.md
# Scannable Modulo-3 Counter

A two-bit counter that cycles through three states under a count-enable input. A synchronous clear input returns it to zero. A registered terminal flag is high while the counter sits in its last state. The two state flip-flops are multiplexed-D scan cells joined into one serial chain. With the test-control input low, the cells ignore the counting logic and form a shift register from the scan input to the scan output. A tester can therefore load any present state, apply one functional clock to capture the next state, and shift the result out. This lets the next-state logic be tested as plain combinational logic.

Call the state bits A (upper, `state[1]`) and B (lower, `state[0]`), and write the state as AB. The functional states are 00, 01 and 10. Code 11 is unused, and the counter leaves it on the first functional clock. Every flip-flop is clocked straight from the `clk` pin, with no gating. A full scan test with twelve capture vectors takes 44 clocks. That is six clocks to check the chain, three clocks per vector, and two clocks for the final unload.

Top module: `mod3_scan_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, the state becomes 00 and `term` becomes 0 at that edge, in either mode.
- R2: With `test_ctl`=1 and `clr`=1, the next state is 00 whatever `cnt_en` is (the clear has priority over counting).
- R3: With `test_ctl`=1, `clr`=0 and `cnt_en`=1, the state steps 00 to 01, 01 to 10, and 10 to 00.
- R4: With `test_ctl`=1 and `clr`=`cnt_en`=0, a legal state is held unchanged.
- R5: `term` is 1 exactly when the state is 10, in both modes, and changes at the same edge as the state.
- R6: With `test_ctl`=1, state 11 goes to 00 on the next clock, whatever `clr` and `cnt_en` are.
- R7: With `test_ctl`=0, each clock loads `scan_in` into A and A into B, and `clr` and `cnt_en` have no effect. `scan_out` always shows B.
- R8: A scan test of 6 flush clocks plus 12 vectors (2 shift clocks and 1 capture clock each) plus 2 unload clocks takes 44 clocks. Every captured next state comes out on `scan_out`, B first, while the following vector shifts in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all flip-flops, taken directly from the pin |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Functional clear, forces state 00 in normal mode |
| cnt_en | input | 1 | Count enable in normal mode |
| test_ctl | input | 1 | 1 selects the counting logic, 0 selects the scan shift path |
| scan_in | input | 1 | Serial input into bit A |
| term | output | 1 | Registered flag, high in state 10 |
| scan_out | output | 1 | Serial output, the value of bit B |

## Verification
Unloading a captured response and loading the next vector happen in the same shift clocks. Each bit seen on `scan_out` belongs to the previous capture, while the bit entering on `scan_in` belongs to the next vector. The bench sets this up by running the full 44-clock scan test with back-to-back vectors. A reference model predicts, for every clock, the outgoing bit and the `term` value seen while the new state moves through. A second overlap is tested by driving `clr` and `cnt_en` high together. The result is judged against the priority that R2 states.

// File: rtl/mod3_scan_pkg.sv
package mod3_scan_pkg;
  localparam int STATE_W = 2;
  typedef logic [STATE_W-1:0] state_t;
  localparam state_t ST_ZERO   = 2'b00;
  localparam state_t ST_ONE    = 2'b01;
  localparam state_t ST_TWO    = 2'b10;
  localparam state_t ST_UNUSED = 2'b11;
endpackage

// File: rtl/mod3_next_state.sv
module mod3_next_state
  import mod3_scan_pkg::*;
(
  input  state_t cur,
  input  logic   clr,
  input  logic   cnt_en,
  output state_t nxt
);
  always_comb begin
    if (clr || cur == ST_UNUSED) begin
      nxt = ST_ZERO;
    end else if (cnt_en) begin
      case (cur)
        ST_ZERO: nxt = ST_ONE;
        ST_ONE:  nxt = ST_TWO;
        default: nxt = ST_ZERO;
      endcase
    end else begin
      nxt = cur;
    end
  end
endmodule

// File: rtl/scan_dff.sv
module scan_dff #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic test_ctl,
  input  logic d_func,
  input  logic d_scan,
  output logic d_sel,
  output logic q
);
  // test_ctl high picks the functional input, low picks the shift path
  assign d_sel = test_ctl ? d_func : d_scan;

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= d_sel;
  end
endmodule

// File: rtl/mod3_scan_counter.sv
module mod3_scan_counter
  import mod3_scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cnt_en,
  input  logic test_ctl,
  input  logic scan_in,
  output logic term,
  output logic scan_out
);
  localparam int LAST = STATE_W - 1;

  state_t state_q;
  state_t func_nxt;
  state_t sel_nxt;
  logic   term_q;

  mod3_next_state u_next (
    .cur    (state_q),
    .clr    (clr),
    .cnt_en (cnt_en),
    .nxt    (func_nxt)
  );

  for (genvar i = 0; i < STATE_W; i++) begin : g_chain
    logic d_scan;
    if (i == LAST) begin : g_head
      assign d_scan = scan_in;
    end else begin : g_link
      assign d_scan = state_q[i+1];
    end
    scan_dff #(.RESET_VAL(ST_ZERO[i])) u_cell (
      .clk      (clk),
      .rst      (rst),
      .test_ctl (test_ctl),
      .d_func   (func_nxt[i]),
      .d_scan   (d_scan),
      .d_sel    (sel_nxt[i]),
      .q        (state_q[i])
    );
  end

  // flag decoded from the value the chain is about to take
  always_ff @(posedge clk) begin
    if (rst) term_q <= 1'b0;
    else     term_q <= (sel_nxt == ST_TWO);
  end

  assign term     = term_q;
  assign scan_out = state_q[0];
endmodule

// File: rtl/mod3_scan_counter_chk.sv
module mod3_scan_counter_chk
  import mod3_scan_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   clr,
  input logic   cnt_en,
  input logic   test_ctl,
  input logic   scan_in,
  input state_t state,
  input logic   term
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (state == ST_ZERO && !term)); // R1
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (test_ctl && clr) |=> state == ST_ZERO); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (test_ctl && !clr && cnt_en && state != ST_UNUSED) |=>
    state == (($past(state) == ST_TWO) ? ST_ZERO : $past(state) + 2'd1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (test_ctl && !clr && !cnt_en && state != ST_UNUSED) |=> $stable(state)); // R4
  AST_TERM_DECODE: assert property (@(posedge clk) disable iff (rst)
    term == (state == ST_TWO)); // R5
  AST_UNUSED_EXIT: assert property (@(posedge clk) disable iff (rst)
    (test_ctl && state == ST_UNUSED) |=> state == ST_ZERO); // R6
  AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
    !test_ctl |=> state[1] == $past(scan_in)); // R7
  AST_SHIFT_LINK: assert property (@(posedge clk) disable iff (rst)
    !test_ctl |=> state[0] == $past(state[1])); // R7
endmodule

bind mod3_scan_counter mod3_scan_counter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .cnt_en   (cnt_en),
  .test_ctl (test_ctl),
  .scan_in  (scan_in),
  .state    (state_q),
  .term     (term)
);

// File: tb/mod3_scan_counter_test.sv
`timescale 1ns/1ps
module mod3_scan_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, cnt_en = 1'b0, test_ctl = 1'b1, scan_in = 1'b0;
  logic term, scan_out;

  int tests = 0, fails = 0;
  logic [1:0] model = 2'b00;
  logic  q_z[$];
  logic  q_so[$];
  string q_tag[$];
  int    cyc_count = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  mod3_scan_counter uut (
    .clk(clk), .rst(rst), .clr(clr), .cnt_en(cnt_en), .test_ctl(test_ctl),
    .scan_in(scan_in), .term(term), .scan_out(scan_out)
  );

  // driver: apply one clock of stimulus and push the predicted result
  task automatic drive(input logic t, input logic r, input logic c,
                       input logic s, input logic rs, input string tag);
    logic [1:0] nx;
    @(negedge clk);
    test_ctl = t; clr = r; cnt_en = c; scan_in = s; rst = rs;
    if (rs)                         nx = 2'b00;
    else if (!t)                    nx = {s, model[1]};
    else if (r || model == 2'b11)   nx = 2'b00;
    else if (c)                     nx = (model == 2'b10) ? 2'b00 : model + 2'b01;
    else                            nx = model;
    model = nx;
    q_z.push_back(nx == 2'b10);
    q_so.push_back(nx[0]);
    q_tag.push_back(tag);
    cyc_count++;
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      logic  ez, es;
      string tg;
      ez = q_z.pop_front(); es = q_so.pop_front(); tg = q_tag.pop_front();
      tests++;
      if (term !== ez || scan_out !== es) begin
        fails++;
        $display("FAIL %s: term=%b scan_out=%b expected term=%b scan_out=%b",
                 tg, term, scan_out, ez, es);
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] vec [12];
    // each vector: {A, B, clr, cnt_en}
    vec[0]=4'b0001; vec[1]=4'b0101; vec[2]=4'b1001;  vec[3]=4'b1101;
    vec[4]=4'b0000; vec[5]=4'b0100; vec[6]=4'b1000;  vec[7]=4'b1100;
    vec[8]=4'b0010; vec[9]=4'b0111; vec[10]=4'b1010; vec[11]=4'b1110;

    drive(1,0,0,0,1,"R1 reset");
    drive(1,0,1,0,1,"R1 reset with count");
    // R3 / R5 counting sequence
    drive(1,0,1,0,0,"R3 count 00->01");
    drive(1,0,1,0,0,"R5 count 01->10 term high");
    drive(1,0,1,0,0,"R3 count 10->00");
    drive(1,0,1,0,0,"R3 count 00->01");
    // R4 hold
    for (int i = 0; i < 3; i++) drive(1,0,0,1,0,"R4 hold 01");
    drive(1,0,1,0,0,"R3 count 01->10");
    drive(1,0,0,0,0,"R4 hold 10");
    // R2 clear wins over count
    drive(1,1,1,0,0,"R2 clear with count");
    drive(1,0,1,0,0,"R3 count after clear");
    // R7 shift load 11 while clr/cnt_en are high
    drive(0,1,1,1,0,"R7 shift ignores clr");
    drive(0,1,1,1,0,"R7 shift ignores cnt_en");
    drive(1,0,0,0,0,"R6 unused to zero idle");
    drive(0,0,0,1,0,"R7 shift");
    drive(0,0,0,1,0,"R7 shift");
    drive(1,0,1,0,0,"R6 unused to zero counting");
    // R5 term in scan mode: load 10
    drive(0,0,0,0,0,"R7 shift 0");
    drive(0,0,0,1,0,"R5 term in scan");
    drive(0,0,0,1,1,"R1 reset in scan mode");
    // R8 full scan test, 44 clocks
    cyc_count = 0;
    drive(0,0,0,0,0,"R8 flush"); drive(0,0,0,0,0,"R8 flush");
    drive(0,0,0,1,0,"R8 flush"); drive(0,0,0,1,0,"R8 flush");
    drive(0,0,0,0,0,"R8 flush"); drive(0,0,0,0,0,"R8 flush");
    for (int v = 0; v < 12; v++) begin
      drive(0,0,0,vec[v][2],0,"R8 load/unload");
      drive(0,0,0,vec[v][3],0,"R8 load/unload");
      drive(1,vec[v][1],vec[v][0],0,0,"R8 capture");
    end
    drive(0,0,0,0,0,"R8 unload"); drive(0,0,0,0,0,"R8 unload");
    @(negedge clk);
    tests++;
    if (cyc_count != 44) begin
      fails++;
      $display("FAIL R8 scan test length: got %0d expected 44", cyc_count);
    end
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule